// File: doc/BRIEF.md
# Time Base and Watchdog Interrupt Unit

This block divides a slow reference tick into a programmable square-wave time base and a watchdog time-out flag. Both come from a single shared divider chain. A source running at eight times the nominal rate can be brought down by a selectable prescaler. Either result can be steered onto an active-low, open-drain style interrupt line. That line is modelled as a pull-down enable plus the level the pin would show with an external pull-up.

A host drives single-cycle command pulses into the block: enable or disable the timer or the watchdog, clear either stage, enable or release the interrupt line, and load a rate code. The shared chain causes the timer and watchdog commands to interact. Enabling the watchdog also runs the time base, and disabling either one stops both. Once the watchdog expires, it keeps the line low until software services it.

Top module: `tbw_irq_unit`

## Requirements
- R1: With `presc_sel_i`=1 one base tick is produced for every PRESC_DIV qualified source ticks, counted across gaps between source ticks. With `presc_sel_i`=0 every qualified source tick is a base tick.
- R2: With rate code c, the time-base level is a 50% square wave of period 2^(TB_LOG2 + 2^RATE_W − 1 − c) base ticks. It starts low after a clear. After reset the rate code is all ones, the fastest rate.
- R3: While the chain runs, the watchdog flag sets at the end of the fourth full time-base period after a watchdog clear.
- R4: `wdt_en_i` starts the chain and routes the watchdog flag to the interrupt. `tmr_en_i` starts the chain and routes the time base. If both arrive in the same cycle, the watchdog route wins.
- R5: Either disable pulse stops the shared chain and freezes its level and counts. A disable beats an enable that arrives in the same cycle.
- R6: `clr_wdt_i` zeroes the chain, the watchdog stage and the flag. `clr_tmr_i` zeroes only the chain. A clear beats a base tick, and it beats an enable, in the same cycle.
- R7: Once set, the watchdog flag stays set until `clr_wdt_i` or `irq_dis_i`. While the watchdog route is selected, the interrupt is pulled low for exactly as long as the flag is set.
- R8: The interrupt output is disabled after reset and after `irq_dis_i`, and enabled by `irq_en_i`. When disabled, `irq_oe_o`=0 and `irq_n_o`=1.
- R9: While `sys_en_i`=0 no base tick occurs and the prescaler holds, so the time base and watchdog stop.
- R10: On the time-base route, the line is pulled low (`irq_oe_o`=1, `irq_n_o`=0) only while the chain runs and the level is low. A stopped chain releases it.
- R11: Each command pulse takes effect at the next rising clock edge and is visible on the outputs directly after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 1 | One pulse per reference oscillator period |
| presc_sel_i | input | 1 | 1 = divide source ticks by PRESC_DIV |
| sys_en_i | input | 1 | System clock enable; 0 freezes the block |
| tmr_en_i | input | 1 | Pulse: run chain, route time base |
| tmr_dis_i | input | 1 | Pulse: stop chain |
| wdt_en_i | input | 1 | Pulse: run chain, route watchdog flag |
| wdt_dis_i | input | 1 | Pulse: stop chain |
| clr_tmr_i | input | 1 | Pulse: clear divider chain |
| clr_wdt_i | input | 1 | Pulse: clear chain, watchdog stage and flag |
| irq_en_i | input | 1 | Pulse: enable interrupt output |
| irq_dis_i | input | 1 | Pulse: disable interrupt output, drop flag |
| rate_wr_i | input | 1 | Pulse: load rate code |
| rate_i | input | RATE_W | Rate code to load |
| irq_n_o | output | 1 | Pin level seen with pull-up (0 = asserted) |
| irq_oe_o | output | 1 | Pull-down enable of the open-drain pin |

## Verification
The bench keeps PRESC_DIV at 8 but shrinks TB_LOG2 to 2 and RATE_W to 2. The chain then has five bits, and every rate code has a period between 4 and 32 base ticks. At these sizes a watchdog expiry at each rate, a wrap of the whole chain and the prescaled case all fit in a few hundred clocks. Gapped source ticks, frozen system clock and same-cycle command collisions can all be checked against the per-cycle model.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

  typedef enum logic {
    ROUTE_TB  = 1'b0,
    ROUTE_WDT = 1'b1
  } route_e;

  // Bit of the chain that carries the time-base level for a rate code.
  function automatic int unsigned level_idx(int unsigned tb_log2, int unsigned rate_w,
                                            int unsigned code);
    return tb_log2 + (32'd1 << rate_w) - 32'd2 - code;
  endfunction

  // One-hot mask selecting the level bit.
  function automatic int unsigned half_bit(int unsigned tb_log2, int unsigned rate_w,
                                           int unsigned code);
    return 32'd1 << level_idx(tb_log2, rate_w, code);
  endfunction

  // All chain bits below and including the level bit: all ones = last tick of a period.
  function automatic int unsigned period_mask(int unsigned tb_log2, int unsigned rate_w,
                                              int unsigned code);
    return (half_bit(tb_log2, rate_w, code) << 1) - 32'd1;
  endfunction

endpackage

// File: rtl/tbw_prescale.sv
module tbw_prescale #(
  parameter int PRESC_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_tick_i,
  input  logic presc_sel_i,
  input  logic sys_en_i,
  output logic base_tick_o
);
  localparam int PW = $clog2(PRESC_DIV);

  logic [PW-1:0] pc_q;
  logic          adv;
  logic          at_last;

  assign adv     = sys_en_i & src_tick_i;
  assign at_last = (pc_q == PW'(PRESC_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (adv && presc_sel_i) begin
      pc_q <= at_last ? '0 : pc_q + 1'b1;
    end
  end

  assign base_tick_o = adv & (~presc_sel_i | at_last);

  // R1: in divided mode two base ticks are never adjacent
  p_presc_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_tick_o && presc_sel_i) |=> !(base_tick_o && presc_sel_i));

  // R9: frozen system clock holds the prescaler
  p_presc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_en_i |=> $stable(pc_q));

endmodule

// File: rtl/tbw_chain.sv
module tbw_chain #(
  parameter int TB_LOG2 = 8,
  parameter int RATE_W  = 3,
  parameter int WDT_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clr_tb_i,
  input  logic              clr_wdt_i,
  input  logic              flag_drop_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              level_o,
  output logic              period_end_o,
  output logic              wdt_flag_o
);
  localparam int CW = TB_LOG2 + (1 << RATE_W) - 1;

  logic [CW-1:0]    chain_q;
  logic [WDT_W-1:0] wdt_q;
  logic             flag_q;
  logic [CW-1:0]    half_m;
  logic [CW-1:0]    per_m;
  logic             clr_any;

  assign half_m  = CW'(tbw_pkg::half_bit(TB_LOG2, RATE_W, 32'(rate_i)));
  assign per_m   = CW'(tbw_pkg::period_mask(TB_LOG2, RATE_W, 32'(rate_i)));
  assign clr_any = clr_tb_i | clr_wdt_i;

  assign level_o      = |(chain_q & half_m);
  assign period_end_o = step_i & ~clr_any & ((chain_q & per_m) == per_m);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else if (clr_any) begin
      chain_q <= '0;
    end else if (step_i) begin
      chain_q <= chain_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_q <= '0;
    end else if (clr_wdt_i) begin
      wdt_q <= '0;
    end else if (period_end_o) begin
      wdt_q <= wdt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (clr_wdt_i || flag_drop_i) begin
      flag_q <= 1'b0;
    end else if (period_end_o && (&wdt_q)) begin
      flag_q <= 1'b1;
    end
  end

  assign wdt_flag_o = flag_q;

  // R6: any clear leaves the chain at zero
  p_clear_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_any |=> (chain_q == '0));

  // R6: timer clear alone keeps the watchdog stage
  p_wdt_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_tb_i && !clr_wdt_i && !step_i) |=> (wdt_q == $past(wdt_q)));

  // R7: flag is sticky until serviced
  p_flag_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_wdt_i && !flag_drop_i) |=> flag_q);

  // R3: flag only rises at a period boundary
  p_flag_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(period_end_o));

  // R5: without a step the chain does not move
  p_chain_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_any) |=> $stable(chain_q));

endmodule

// File: rtl/tbw_ctrl.sv
module tbw_ctrl #(
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_en_i,
  input  logic              tmr_dis_i,
  input  logic              wdt_en_i,
  input  logic              wdt_dis_i,
  input  logic              irq_en_i,
  input  logic              irq_dis_i,
  input  logic              rate_wr_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              level_i,
  input  logic              wdt_flag_i,
  output logic              run_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              irq_oe_o,
  output logic              irq_n_o
);
  import tbw_pkg::*;

  localparam logic [RATE_W-1:0] RATE_DFLT = '1;

  logic              run_q;
  route_e            route_q;
  logic              ien_q;
  logic [RATE_W-1:0] rate_q;
  logic              low_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      route_q <= ROUTE_TB;
      ien_q   <= 1'b0;
      rate_q  <= RATE_DFLT;
    end else begin
      if (tmr_dis_i || wdt_dis_i)      run_q <= 1'b0;
      else if (tmr_en_i || wdt_en_i)   run_q <= 1'b1;

      if (wdt_en_i)                    route_q <= ROUTE_WDT;
      else if (tmr_en_i)               route_q <= ROUTE_TB;

      if (irq_dis_i)                   ien_q <= 1'b0;
      else if (irq_en_i)               ien_q <= 1'b1;

      if (rate_wr_i)                   rate_q <= rate_i;
    end
  end

  assign low_req  = (route_q == ROUTE_WDT) ? wdt_flag_i : (run_q & ~level_i);
  assign irq_oe_o = ien_q & low_req;
  assign irq_n_o  = ~irq_oe_o;
  assign run_o    = run_q;
  assign rate_o   = rate_q;

  // R8: a disable pulse releases the line at the next edge
  p_irq_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_dis_i |=> !irq_oe_o);

  // R5: a disable wins over an enable
  p_dis_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_dis_i || wdt_dis_i) |=> !run_o);

  // R4: watchdog enable takes the route
  p_route_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_en_i |=> (route_q == ROUTE_WDT));

  // R10: a stopped chain on the time-base route never pulls the line
  p_tb_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((route_q == ROUTE_TB) && !run_q) |-> !irq_oe_o);

endmodule

// File: rtl/tbw_irq_unit.sv
module tbw_irq_unit #(
  parameter int PRESC_DIV = 8,
  parameter int TB_LOG2   = 8,
  parameter int RATE_W    = 3,
  parameter int WDT_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_tick_i,
  input  logic              presc_sel_i,
  input  logic              sys_en_i,
  input  logic              tmr_en_i,
  input  logic              tmr_dis_i,
  input  logic              wdt_en_i,
  input  logic              wdt_dis_i,
  input  logic              clr_tmr_i,
  input  logic              clr_wdt_i,
  input  logic              irq_en_i,
  input  logic              irq_dis_i,
  input  logic              rate_wr_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              irq_n_o,
  output logic              irq_oe_o
);
  logic              base_tick;
  logic              step;
  logic              run;
  logic              level;
  logic              period_end;
  logic              wdt_flag;
  logic [RATE_W-1:0] rate_q;

  tbw_prescale #(.PRESC_DIV(PRESC_DIV)) u_presc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_tick_i  (src_tick_i),
    .presc_sel_i (presc_sel_i),
    .sys_en_i    (sys_en_i),
    .base_tick_o (base_tick)
  );

  assign step = base_tick & run;

  tbw_chain #(.TB_LOG2(TB_LOG2), .RATE_W(RATE_W), .WDT_W(WDT_W)) u_chain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (step),
    .clr_tb_i     (clr_tmr_i),
    .clr_wdt_i    (clr_wdt_i),
    .flag_drop_i  (irq_dis_i),
    .rate_i       (rate_q),
    .level_o      (level),
    .period_end_o (period_end),
    .wdt_flag_o   (wdt_flag)
  );

  tbw_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tmr_en_i   (tmr_en_i),
    .tmr_dis_i  (tmr_dis_i),
    .wdt_en_i   (wdt_en_i),
    .wdt_dis_i  (wdt_dis_i),
    .irq_en_i   (irq_en_i),
    .irq_dis_i  (irq_dis_i),
    .rate_wr_i  (rate_wr_i),
    .rate_i     (rate_i),
    .level_i    (level),
    .wdt_flag_i (wdt_flag),
    .run_o      (run),
    .rate_o     (rate_q),
    .irq_oe_o   (irq_oe_o),
    .irq_n_o    (irq_n_o)
  );

  // R9: no base tick while the system clock is off
  p_halt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_en_i |-> !base_tick);

  // R3: a period can only end while the chain steps
  p_pend_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |-> step);

endmodule

// File: tb/test_tbw_irq_unit.sv
module test_tbw_irq_unit;
  localparam int PD   = 8;
  localparam int TBL  = 2;
  localparam int RW   = 2;
  localparam int MAXC = 3;      // largest rate code
  localparam int WRAP = 32;     // 2^(TBL + MAXC)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_tick = 1'b0, presc_sel = 1'b0, sys_en = 1'b1;
  logic tmr_en = 0, tmr_dis = 0, wdt_en = 0, wdt_dis = 0;
  logic clr_tmr = 0, clr_wdt = 0, irq_en = 0, irq_dis = 0, rate_wr = 0;
  logic [RW-1:0] rate = '0;
  logic irq_n, irq_oe;

  int checks = 0, failures = 0, ncyc = 0, src_mode = 0;
  bit done = 0;
  string tag = "R8";

  // reference model state
  int m_pc, m_cnt, m_wp, m_rate;
  bit m_flag, m_run, m_wdt, m_ien;

  always #10 clk = ~clk;

  tbw_irq_unit #(.PRESC_DIV(PD), .TB_LOG2(TBL), .RATE_W(RW), .WDT_W(2)) i_tbw_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick), .presc_sel_i(presc_sel),
    .sys_en_i(sys_en), .tmr_en_i(tmr_en), .tmr_dis_i(tmr_dis), .wdt_en_i(wdt_en),
    .wdt_dis_i(wdt_dis), .clr_tmr_i(clr_tmr), .clr_wdt_i(clr_wdt), .irq_en_i(irq_en),
    .irq_dis_i(irq_dis), .rate_wr_i(rate_wr), .rate_i(rate),
    .irq_n_o(irq_n), .irq_oe_o(irq_oe));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_cnt = 0; m_wp = 0; m_rate = MAXC;
      m_flag = 0; m_run = 0; m_wdt = 0; m_ien = 0;
    end else begin
      int per;
      bit tick, stp, pend, clr;
      per  = 2 ** (TBL + MAXC - m_rate);
      tick = src_tick && sys_en && (!presc_sel || m_pc == PD - 1);
      if (src_tick && sys_en && presc_sel) m_pc = (m_pc + 1) % PD;
      stp  = tick && m_run;
      clr  = clr_tmr || clr_wdt;
      pend = stp && !clr && (m_cnt % per == per - 1);
      if (clr_wdt || irq_dis) m_flag = 0;
      else if (pend && m_wp == 3) m_flag = 1;
      if (clr_wdt) m_wp = 0;
      else if (pend) m_wp = (m_wp + 1) % 4;
      if (clr) m_cnt = 0;
      else if (stp) m_cnt = (m_cnt + 1) % WRAP;
      if (tmr_dis || wdt_dis) m_run = 0;
      else if (tmr_en || wdt_en) m_run = 1;
      if (wdt_en) m_wdt = 1;
      else if (tmr_en) m_wdt = 0;
      if (irq_dis) m_ien = 0;
      else if (irq_en) m_ien = 1;
      if (rate_wr) m_rate = int'(rate);
    end
  end

  function automatic bit exp_oe();
    int per;
    bit lvl, low;
    per = 2 ** (TBL + MAXC - m_rate);
    lvl = (m_cnt % per) >= per / 2;
    low = m_wdt ? m_flag : (m_run && !lvl);
    return m_ien && low;
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b cycle=%0d", tag, what, act, exp, ncyc);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(irq_oe, exp_oe(), "irq_oe_o");
    chk(irq_n, ~exp_oe(), "irq_n_o");
    ncyc++;
    src_tick = (src_mode == 0) ? 1'b1 : ((ncyc % 3) != 0);
    {tmr_en, tmr_dis, wdt_en, wdt_dis, clr_tmr, clr_wdt, irq_en, irq_dis, rate_wr} = '0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tag = "R8"; run(4);
    @(negedge clk); rst_n = 1'b1;
    // R8: reset state released
    chk(irq_oe, 1'b0, "reset oe"); chk(irq_n, 1'b1, "reset level");
    run(3);
    // R10: enabled line but stopped chain stays released
    tag = "R10"; irq_en = 1; cyc(); run(6);
    // R6/R10: clear together with enable, default fastest rate
    tag = "R10"; clr_tmr = 1; tmr_en = 1; cyc(); run(40);
    // R2: every rate code
    tag = "R2";
    for (int c = 0; c < MAXC; c++) begin
      rate = RW'(c); rate_wr = 1; clr_tmr = 1; cyc(); run(80);
    end
    rate = RW'(MAXC); rate_wr = 1; clr_tmr = 1; cyc(); run(20);
    // R1: prescaled, regular and gapped source ticks
    tag = "R1"; presc_sel = 1; clr_tmr = 1; cyc(); run(80);
    src_mode = 1; run(120);
    src_mode = 0; presc_sel = 0;
    // R3/R4: watchdog expiry and routing
    tag = "R3"; clr_wdt = 1; wdt_en = 1; cyc(); run(30);
    tag = "R7"; run(15);
    irq_dis = 1; cyc(); run(4);
    tag = "R11"; irq_en = 1; cyc(); run(40);
    // R6: timer clear keeps watchdog stage, watchdog clear resets it
    tag = "R6"; clr_tmr = 1; cyc(); run(10);
    clr_tmr = 1; run(1); run(25);
    clr_wdt = 1; cyc(); run(20);
    // R5: disable freezes, disable beats enable
    tag = "R5"; wdt_dis = 1; cyc(); run(20);
    wdt_dis = 1; wdt_en = 1; cyc(); run(10);
    tmr_en = 1; cyc(); run(12);
    tmr_dis = 1; cyc(); run(10);
    // R4: both enables together route the watchdog
    tag = "R4"; tmr_en = 1; wdt_en = 1; clr_wdt = 1; cyc(); run(25);
    // R9: frozen system clock
    tag = "R9"; sys_en = 0; run(40); sys_en = 1; run(20);
    tag = "R9"; presc_sel = 1; sys_en = 0; run(20); sys_en = 1; run(40);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule